// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block runs the subroutine linkage part of a small 8-bit processor. It fetches opcodes from a byte-wide memory port and holds a 16-bit program counter, an 8-bit stack pointer and a carry flag. A call reads a two-byte target from the instruction stream, saves a return address on the stack and jumps to the target. A return takes the saved address off the stack, reloads the program counter and steps it by one so that execution continues after the call. The block also sets and clears the carry flag. Every other opcode is skipped as a one-byte no-op.

The memory port is a valid/ready request channel. The block raises `mem_valid` with an address, a write enable and write data. The transfer takes place in the cycle where `mem_ready` is also high. Read data on `mem_rdata` belongs to that same cycle. While `mem_ready` is low, the request stays unchanged and no state of the block moves, so the memory can hold back the sequencer for any number of cycles. Cycles that only work inside the block never raise a request. The stack sits in memory page 0x01.

Top module: `callret_seq`

## Requirements
- R1: After reset the program counter is RST_PC (0x0000 by default), the stack pointer is RST_SP (0xFF by default) and the carry flag is 0.
- R2: Opcode 0x20 is a 3-byte call that takes 7 cycles when there are no stalls. The low byte of the target comes first in the stream and the high byte second. When the call ends, the program counter holds the target.
- R3: A call writes two stack bytes. The first is the high byte of the address of the call's last byte, written at 0x0100+SP. The second is the low byte of that address, written at the new 0x0100+SP. SP drops by one after each write.
- R4: Opcode 0x60 is a 1-byte return that takes 6 cycles when there are no stalls. It increments SP and then reads the low byte, then increments SP again and reads the high byte. The program counter ends at the popped address plus 1.
- R5: The stack pointer wraps modulo 256 in both directions: a pop at SP=0xFF reads 0x0100, and a push at SP=0x00 leaves SP=0xFF.
- R6: Opcode 0x38 sets the carry flag to 1 and opcode 0x18 clears it to 0. Each takes 2 cycles and advances the program counter by 1.
- R7: Any other opcode takes 2 cycles and advances the program counter by 1. It writes no memory and leaves SP and carry unchanged.
- R8: While `mem_valid` is high and `mem_ready` is low, the address, write enable and write data stay stable, and the program counter and SP hold. Internal cycles make no request.
- R9: `instr_done` is high for exactly the last cycle of each instruction. That cycle never carries a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for an accepted read, same cycle |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| carry | output | 1 | Carry flag |
| instr_done | output | 1 | Last cycle of the current instruction |

## Verification
The overlap of interest is a memory stall arriving on a push or pop cycle. In that cycle the handshake and the stack pointer update meet, and a wrong gate would move SP without a transfer taking place, or write twice. The bench runs the same call/return program twice: once with `mem_ready` held high, and once with `mem_ready` dropped pseudo-randomly. The second run must reach the same program counter, SP, carry and per-instruction write count after every instruction, and must leave the same stack bytes. The bench also checks that every stalled request stays stable.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [3:0] {
    S_FETCH,
    S_TGT_LO,
    S_TGT_HI,
    S_JOIN,
    S_PUSH_HI,
    S_PUSH_LO,
    S_JUMP,
    S_POP_LO,
    S_POP_HI,
    S_RJOIN,
    S_RLOAD,
    S_RINC,
    S_FLAG,
    S_SKIP
  } seq_state_e;

  typedef enum logic [1:0] {
    K_CALL,
    K_RET,
    K_FLAG,
    K_OTHER
  } op_kind_e;

  localparam logic [7:0] OP_CALL = 8'h20;
  localparam logic [7:0] OP_RET  = 8'h60;
  localparam logic [7:0] OP_SETC = 8'h38;
  localparam logic [7:0] OP_CLRC = 8'h18;

endpackage

// File: rtl/callret_decode.sv
module callret_decode
  import callret_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  output op_kind_e         kind,
  output logic             flag_val
);

  always_comb begin
    kind     = K_OTHER;
    flag_val = 1'b0;
    case (opcode)
      OP_CALL: kind = K_CALL;
      OP_RET:  kind = K_RET;
      OP_SETC: begin
        kind     = K_FLAG;
        flag_val = 1'b1;
      end
      OP_CLRC: kind = K_FLAG;
      default: kind = K_OTHER;
    endcase
  end

endmodule

// File: rtl/callret_sp.sv
module callret_sp #(
  parameter int              SP_W   = 8,
  parameter logic [SP_W-1:0] RST_SP = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_en,
  input  logic            inc_en,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_next_up
);

  logic [SP_W-1:0] sp_q;

  assign sp         = sp_q;
  assign sp_next_up = sp_q + SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= RST_SP;
    else if (dec_en) sp_q <= sp_q - SP_W'(1);
    else if (inc_en) sp_q <= sp_next_up;
  end

  AST_SP_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_en && inc_en)); // R5

endmodule

// File: rtl/callret_pc.sv
module callret_pc #(
  parameter int              PC_W   = 16,
  parameter logic [PC_W-1:0] RST_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_en,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] pc
);

  logic [PC_W-1:0] pc_q;

  assign pc = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= RST_PC;
    else if (load_en) pc_q <= load_val;
    else if (inc_en)  pc_q <= pc_q + PC_W'(1);
  end

  AST_PC_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && inc_en)); // R2

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter logic [15:0]      RST_PC     = 16'h0000,
  parameter logic [7:0]       RST_SP     = 8'hFF,
  parameter logic [7:0]       STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic        carry,
  output logic        instr_done
);

  localparam int ADDR_W = 2 * DATA_W;

  seq_state_e        st_q, st_nxt;
  op_kind_e          dec_kind;
  logic              dec_flag;
  logic              flag_val_q;
  logic              carry_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              sp_dec, sp_inc;
  logic              pc_inc, pc_load;
  logic [DATA_W-1:0] sp_up;
  logic              xfer;

  callret_decode #(.OPC_W(DATA_W)) u_decode (
    .opcode   (mem_rdata),
    .kind     (dec_kind),
    .flag_val (dec_flag)
  );

  callret_sp #(.SP_W(DATA_W), .RST_SP(RST_SP)) u_sp (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_en     (sp_dec),
    .inc_en     (sp_inc),
    .sp         (sp),
    .sp_next_up (sp_up)
  );

  callret_pc #(.PC_W(ADDR_W), .RST_PC(RST_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (pc_inc),
    .load_en  (pc_load),
    .load_val (tgt_q),
    .pc       (pc)
  );

  assign xfer  = mem_valid && mem_ready;
  assign carry = carry_q;

  always_comb begin
    st_nxt     = st_q;
    mem_valid  = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = pc;
    mem_wdata  = '0;
    sp_dec     = 1'b0;
    sp_inc     = 1'b0;
    pc_inc     = 1'b0;
    pc_load    = 1'b0;
    instr_done = 1'b0;
    case (st_q)
      S_FETCH: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          pc_inc = 1'b1;
          case (dec_kind)
            K_CALL:  st_nxt = S_TGT_LO;
            K_RET:   st_nxt = S_POP_LO;
            K_FLAG:  st_nxt = S_FLAG;
            default: st_nxt = S_SKIP;
          endcase
        end
      end
      S_TGT_LO: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          pc_inc = 1'b1;
          st_nxt = S_TGT_HI;
        end
      end
      S_TGT_HI: begin
        mem_valid = 1'b1;
        if (mem_ready) st_nxt = S_JOIN;
      end
      S_JOIN: st_nxt = S_PUSH_HI;
      S_PUSH_HI: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pc[15:8];
        if (mem_ready) begin
          sp_dec = 1'b1;
          st_nxt = S_PUSH_LO;
        end
      end
      S_PUSH_LO: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pc[7:0];
        if (mem_ready) begin
          sp_dec = 1'b1;
          st_nxt = S_JUMP;
        end
      end
      S_JUMP: begin
        pc_load    = 1'b1;
        instr_done = 1'b1;
        st_nxt     = S_FETCH;
      end
      S_POP_LO: begin
        mem_valid = 1'b1;
        mem_addr  = {STACK_PAGE, sp_up};
        if (mem_ready) begin
          sp_inc = 1'b1;
          st_nxt = S_POP_HI;
        end
      end
      S_POP_HI: begin
        mem_valid = 1'b1;
        mem_addr  = {STACK_PAGE, sp_up};
        if (mem_ready) begin
          sp_inc = 1'b1;
          st_nxt = S_RJOIN;
        end
      end
      S_RJOIN: st_nxt = S_RLOAD;
      S_RLOAD: begin
        pc_load = 1'b1;
        st_nxt  = S_RINC;
      end
      S_RINC: begin
        pc_inc     = 1'b1;
        instr_done = 1'b1;
        st_nxt     = S_FETCH;
      end
      S_FLAG: begin
        instr_done = 1'b1;
        st_nxt     = S_FETCH;
      end
      S_SKIP: begin
        instr_done = 1'b1;
        st_nxt     = S_FETCH;
      end
      default: st_nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_FETCH;
      flag_val_q <= 1'b0;
      carry_q    <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
      tgt_q      <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q == S_FETCH && xfer) flag_val_q <= dec_flag;
      if ((st_q == S_TGT_LO || st_q == S_POP_LO) && xfer) lo_q <= mem_rdata;
      if ((st_q == S_TGT_HI || st_q == S_POP_HI) && xfer) hi_q <= mem_rdata;
      if (st_q == S_JOIN || st_q == S_RJOIN) tgt_q <= {hi_q, lo_q};
      if (st_q == S_FLAG) carry_q <= flag_val_q;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> ($stable(pc) && $stable(sp))); // R8

  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == STACK_PAGE)); // R3

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (sp == $past(sp) - 8'd1)); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_JUMP) |=> (pc == $past(tgt_q))); // R2

  AST_RET_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RINC) |=> (pc == $past(tgt_q) + 16'd1)); // R4

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> !mem_valid); // R9

  AST_CARRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (carry != $past(carry)) |-> $past(st_q == S_FLAG)); // R6

endmodule

// File: tb/callret_seq_tb.sv
`timescale 1ns/100ps
module callret_seq_tb;

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        c;
    int          cyc;
    int          wr;
    bit          chk_cyc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_valid, mem_ready, mem_we, carry, instr_done;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, mem_rdata, sp;
  logic [7:0]  mem [0:4095];
  logic [15:0] lfsr = 16'hACE1;
  bit          stall_mode = 1'b0;
  bit          finished = 1'b0;
  int          n_chk = 0, n_fail = 0;
  int          wr_cnt = 0, wr_base = 0;
  int          cnt = 0;
  bit          pend = 1'b0;
  int          stall_events = 0, stall_viol = 0;
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr;
  logic        prev_we;
  exp_t        q[$];
  exp_t        cur;

  always #2.5 clk = ~clk;

  callret_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .carry(carry), .instr_done(instr_done)
  );

  assign mem_rdata = mem[mem_addr[11:0]];
  assign mem_ready = !stall_mode || (lfsr[1:0] != 2'b00);

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n && mem_valid && mem_ready && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_instr(input logic [15:0] epc, input logic [7:0] esp,
                              input logic ec, input int ecyc, input int ewr,
                              input bit chk, input string tag);
    exp_t e;
    e.pc = epc; e.sp = esp; e.c = ec; e.cyc = ecyc; e.wr = ewr;
    e.chk_cyc = chk; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops expected items as instructions complete
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; pend = 0; wr_base = wr_cnt; prev_stall = 0;
    end else begin
      if (prev_stall) begin
        stall_events++;
        if (!mem_valid || mem_addr != prev_addr || mem_we != prev_we) stall_viol++;
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
      if (pend) begin
        check(pc == cur.pc, cur.tag, "pc", pc, cur.pc);
        check(sp == cur.sp, cur.tag, "sp", sp, cur.sp);
        check(carry == cur.c, cur.tag, "carry", carry, cur.c);
        pend = 0;
      end
      cnt++;
      if (instr_done) begin
        if (q.size() != 0) begin
          cur = q.pop_front();
          if (cur.chk_cyc) check(cnt == cur.cyc, cur.tag, "cycles", cnt, cur.cyc);
          check((wr_cnt - wr_base) == cur.wr, cur.tag, "writes", wr_cnt - wr_base, cur.wr);
          pend = 1;
        end
        wr_base = wr_cnt;
        cnt = 0;
      end
    end
  end

  task automatic load_image();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h000] = 8'h38;
    mem[12'h001] = 8'h20; mem[12'h002] = 8'h00; mem[12'h003] = 8'h02;
    mem[12'h004] = 8'hEA;
    mem[12'h005] = 8'h60;
    mem[12'h010] = 8'h18;
    mem[12'h200] = 8'h18;
    mem[12'h201] = 8'h20; mem[12'h202] = 8'hFF; mem[12'h203] = 8'h02;
    mem[12'h204] = 8'h38;
    mem[12'h205] = 8'h60;
    mem[12'h2FF] = 8'h60;
    mem[12'h341] = 8'h20; mem[12'h342] = 8'h10; mem[12'h343] = 8'h00;
    mem[12'h100] = 8'h40; mem[12'h101] = 8'h03;
  endtask

  task automatic queue_program(input bit chk);
    expect_instr(16'h0001, 8'hFF, 1'b1, 2, 0, chk, "R6");
    expect_instr(16'h0200, 8'hFD, 1'b1, 7, 2, chk, "R2");
    expect_instr(16'h0201, 8'hFD, 1'b0, 2, 0, chk, "R6");
    expect_instr(16'h02FF, 8'hFB, 1'b0, 7, 2, chk, "R3");
    expect_instr(16'h0204, 8'hFD, 1'b0, 6, 0, chk, "R4");
    expect_instr(16'h0205, 8'hFD, 1'b1, 2, 0, chk, "R6");
    expect_instr(16'h0004, 8'hFF, 1'b1, 6, 0, chk, "R4");
    expect_instr(16'h0005, 8'hFF, 1'b1, 2, 0, chk, "R7");
    expect_instr(16'h0341, 8'h01, 1'b1, 6, 0, chk, "R5");
    expect_instr(16'h0010, 8'hFF, 1'b1, 7, 2, chk, "R5");
    expect_instr(16'h0011, 8'hFF, 1'b0, 2, 0, chk, "R9");
  endtask

  task automatic run_pass(input bit stalls);
    rst_n = 0;
    stall_mode = stalls;
    load_image();
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc == 16'h0000, "R1", "reset pc", pc, 0);
    check(sp == 8'hFF, "R1", "reset sp", sp, 8'hFF);
    check(carry == 1'b0, "R1", "reset carry", carry, 0);
    queue_program(!stalls);
    @(posedge clk); #1 rst_n = 1;
    while (q.size() != 0 || pend) @(negedge clk);
    @(negedge clk);
    check(mem[12'h1FF] == 8'h00, "R3", "stack 1FF", mem[12'h1FF], 8'h00);
    check(mem[12'h1FE] == 8'h03, "R3", "stack 1FE", mem[12'h1FE], 8'h03);
    check(mem[12'h1FD] == 8'h02, "R3", "stack 1FD", mem[12'h1FD], 8'h02);
    check(mem[12'h1FC] == 8'h03, "R3", "stack 1FC", mem[12'h1FC], 8'h03);
    check(mem[12'h101] == 8'h03, "R5", "stack 101", mem[12'h101], 8'h03);
    check(mem[12'h100] == 8'h43, "R5", "stack 100", mem[12'h100], 8'h43);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    run_pass(1'b0);
    run_pass(1'b1);
    check(stall_events > 0, "R8", "stall events seen", stall_events, 1);
    check(stall_viol == 0, "R8", "stalled request changed", stall_viol, 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule